// File: doc/BRIEF.md
# I2C Row-Wrapping Memory Target

This block is the bus-facing half of a small byte-addressed memory that is reached over a two-wire I2C bus. It oversamples SCL and SDA on the system clock, finds START, repeated START and STOP conditions, and answers only to its own 7-bit device address. In a write transfer, the first byte after the address sets an internal memory pointer. Each byte after that is handed to storage through a one-cycle write strobe. The pointer then steps within the current 8-byte row, so a long burst folds back onto the start of that row instead of spilling into the next one.

Read transfers always start at the pointer's current value. A master that wants a specific location first sends a write that carries only the pointer byte. It then issues a repeated START with the read address. During reads, the pointer advances one step per byte across the whole address space. A STOP that closes a transfer in which data bytes were written raises a one-cycle commit event. The storage side answers with a busy flag while it saves the row. As long as that flag is high, the block refuses its own address, so the master can poll until the save is done.

The storage array sits outside this block. The block presents the pointer on `rd_addr` and expects the byte at that location on `rd_data` in the same cycle.

Top module: `i2c_mem_target`

## Requirements
- R1: While `rst_n` is low and right after it is released, `sda_oe`, `wr_en` and `commit_o` are 0 and `rd_addr` is 0.
- R2: The block pulls SDA low in the acknowledge slot of an address byte only when bits 7..1 of that byte equal `DEV_ADDR`. After any other address it does not drive SDA, acknowledges nothing and writes nothing until the next START.
- R3: In a write transfer (bit 0 of the address byte is 0), the byte after the address byte is acknowledged and loaded into the pointer, which then shows on `rd_addr`.
- R4: Each further write byte is acknowledged and produces exactly one single-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte (first bit received is bit 7).
- R5: After each written byte, the low 3 bits of the pointer increment modulo 8 and the upper bits stay unchanged. A burst longer than 8 bytes therefore overwrites the start of the same row.
- R6: While `busy_i` is high at the end of the address byte, the address is not acknowledged for either direction, and nothing is written.
- R7: A STOP pulses `commit_o` for exactly one cycle if at least one data byte was written since the previous STOP. A STOP after an address-plus-pointer write, or after a read, does not pulse it.
- R8: A read transfer (bit 0 of the address byte is 1) sends, MSB first, the byte at the current pointer, without any pointer byte being sent first.
- R9: A write holding only the pointer byte, followed by a repeated START and a read address, makes the read return data from that pointer.
- R10: During reads, the pointer increments by one after each byte across the full address space, wrapping from the top address to 0.
- R11: After the master NACKs a read byte, the block releases SDA and leaves it released for any further SCL pulses until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Storage is saving a row; refuse the device address |
| wr_en | output | 1 | One-cycle byte write strobe toward storage |
| wr_addr | output | AW | Address of the byte being written |
| wr_data | output | 8 | Byte being written |
| commit_o | output | 1 | One-cycle event: STOP ended a transfer that wrote data |
| rd_addr | output | AW | Current pointer, location to read |
| rd_data | input | 8 | Storage byte at `rd_addr` |

## Verification
The bench goes after the row fold by writing ten bytes that start three places before the end of a row. A design that carried into the upper pointer bits would modify the next row and leave the wrong bytes in the current one. It reads across the top of the address space and repeats a random read through a pointer-only write. A design that row-wrapped reads or kept the old pointer would return the wrong bytes. It also sends a foreign address, a busy address and a pointer-only write, and extra clocks after a NACK. Designs that acknowledge foreign traffic, commit without data, or keep driving SDA after the NACK show up as wrong ACK levels, unexpected writes or commit pulses, or a low SDA line.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types and sizes for the I2C memory target.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = 3;

    // Protocol phase of the target.
    typedef enum logic [3:0] {
        ST_IDLE,      // not addressed; waits for START
        ST_ADDR,      // shifting in device address byte
        ST_ADDR_ACK,  // acknowledge slot of the address byte
        ST_PTR,       // shifting in pointer byte
        ST_PTR_ACK,   // acknowledge slot of the pointer byte
        ST_WDATA,     // shifting in write data byte
        ST_WDATA_ACK, // acknowledge slot of a write data byte
        ST_RDATA,     // shifting out read data byte
        ST_RACK       // master acknowledge slot after read byte
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings SCL and SDA into the clock domain through two flops each
// and derives SCL edges plus START and STOP events.
// Assumes: the system clock is many times faster than SCL, so one sample
// per bus level change is always seen; pad filtering happens elsewhere.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [1:0] scl_pipe;
    logic [1:0] sda_pipe;
    logic       scl_q;
    logic       sda_q;

    // Two-flop synchronizers plus one history flop per line; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    // Edge and condition decode from current and previous synchronized levels.
    always_comb begin
        scl_s    = scl_pipe[1];
        sda_s    = sda_pipe[1];
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_mem_ptr.sv
// Module: memory pointer with a load port, a row-bounded write step and a
// full-range read step.
// Assumes: at most one of load, wstep and rstep is high in a cycle.
module i2c_mem_ptr #(
    parameter int AW = 8,
    parameter int RB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] din,
    input  logic          wstep,
    input  logic          rstep,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] w_next;
    logic [AW-1:0] r_next;

    // Read step covers the whole address space.
    always_comb r_next = ptr + AW'(1);

    generate
        if (RB >= AW) begin : g_row_is_all
            // The row spans the whole space: same as the read step.
            always_comb w_next = ptr + AW'(1);
        end else begin : g_row_split
            // Low RB bits roll over, row bits hold.
            always_comb w_next = {ptr[AW-1:RB], ptr[RB-1:0] + RB'(1)};
        end
    endgenerate

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (load)   ptr <= din;
        else if (wstep)  ptr <= w_next;
        else if (rstep)  ptr <= r_next;
    end

endmodule

// File: rtl/i2c_mem_target.sv
// Module: I2C target front end for a byte-addressed memory. Decodes bus
// conditions, matches the device address, loads a pointer, streams write
// bytes into one row and read bytes from the pointer, and flags commits.
// Assumes: SDA is open drain (sda_oe=1 pulls low); storage returns rd_data
// for rd_addr combinationally; no clock stretching is needed.
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         AW       = 8,
    parameter int         ROW_BITS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          busy_i,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          commit_o,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    tgt_state_t        state;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_rdy;
    logic              rd_mode;
    logic              more_rd;
    logic              wrote;
    logic              ptr_load, ptr_wstep, ptr_rstep;
    logic [AW-1:0]     ptr;

    i2c_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    // Pointer control: decoded at the edge that closes a byte.
    always_comb begin
        ptr_load  = (state == ST_PTR)   && scl_fall && byte_rdy;
        ptr_wstep = (state == ST_WDATA) && scl_fall && byte_rdy;
        ptr_rstep = (state == ST_RDATA) && scl_fall && (bit_cnt == LAST_BIT);
    end

    i2c_mem_ptr #(
        .AW (AW),
        .RB (ROW_BITS)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .din   (AW'(shreg)),
        .wstep (ptr_wstep),
        .rstep (ptr_rstep),
        .ptr   (ptr)
    );

    always_comb rd_addr = ptr;

    // Protocol sequencer: bit shifting, ACK driving, write strobe, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_rdy <= 1'b0;
            rd_mode  <= 1'b0;
            more_rd  <= 1'b0;
            wrote    <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            commit_o <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            commit_o <= 1'b0;
            if (stop_ev) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                commit_o <= wrote;
                wrote    <= 1'b0;
            end else if (start_ev) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                byte_rdy <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + BIT_CW'(1);
                            if (bit_cnt == LAST_BIT) byte_rdy <= 1'b1;
                        end else if (scl_fall && byte_rdy) begin
                            byte_rdy <= 1'b0;
                            bit_cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR && !busy_i) begin
                                    sda_oe  <= 1'b1;
                                    rd_mode <= shreg[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state   <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                wrote   <= 1'b1;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                shreg   <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                bit_cnt <= '0;
                                state   <= ST_RDATA;
                            end else begin
                                sda_oe  <= 1'b0;
                                state   <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + BIT_CW'(1);
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            more_rd <= ~sda_s;
                        end else if (scl_fall) begin
                            if (more_rd) begin
                                shreg   <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                bit_cnt <= '0;
                                state   <= ST_RDATA;
                            end else begin
                                state   <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_mem_target_chk.sv
// Module: protocol checker for i2c_mem_target, attached with bind.
// Assumes: it observes the target's synchronized bus view and outputs.
module i2c_mem_target_chk #(
    parameter int AW = 8,
    parameter int RB = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          start_ev,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          commit_o,
    input logic          idle_st
);

    logic          have_prev;
    logic [AW-1:0] prev_addr;

    // Remembers the last write address since the most recent START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (start_ev) begin
            have_prev <= 1'b0;
        end else if (wr_en) begin
            have_prev <= 1'b1;
            prev_addr <= wr_addr;
        end
    end

    // R2, R8: SDA is only pulled low while SCL is low.
    p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R4: a write strobe lasts a single cycle.
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: consecutive writes in one transfer stay in the row, low bits step.
    p_row_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_prev) |->
            (wr_addr[AW-1:RB] == prev_addr[AW-1:RB] &&
             wr_addr[RB-1:0] == prev_addr[RB-1:0] + RB'(1)));

    // R7: the commit event is a single cycle.
    p_commit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R11: SDA is released whenever the target is not addressed.
    p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idle_st |-> !sda_oe);

endmodule

bind i2c_mem_target i2c_mem_target_chk #(
    .AW (AW),
    .RB (ROW_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .commit_o (commit_o),
    .idle_st  (state == i2c_tgt_pkg::ST_IDLE)
);

// File: tb/sim_i2c_mem_target.sv
`timescale 1ns/1ps
module sim_i2c_mem_target;

    localparam int Q = 10;
    localparam logic [6:0] DEV = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe, wr_en, commit_o;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic       sda_line;

    logic [7:0] mem   [256];
    logic [7:0] model [256];
    int         wr_cnt = 0;
    int         commit_cnt = 0;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    i2c_mem_target u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .busy_i   (busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit_o (commit_o),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // Storage model and event counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'((i * 37 + 11) % 256);
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (commit_o) commit_cnt <= commit_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic bus_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq; scl = 1'b1; wq; wq; scl = 1'b0;
        end
        sda_m = 1'b1; wq; scl = 1'b1; wq; ack = ~sda_line; wq; scl = 1'b0; wq;
    endtask

    task automatic bus_rbyte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq; scl = 1'b1; wq; b[i] = sda_line; wq; scl = 1'b0;
        end
        sda_m = ~give_ack; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq; sda_m = 1'b1;
    endtask

    // Pointer-only write followed by repeated START and read address.
    task automatic set_ptr_for_read(input logic [7:0] p, input string req);
        logic a;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a); chk({req, " addr ack"}, a, 1);
        bus_wbyte(p, a);           chk({req, " ptr ack"}, a, 1);
        bus_start;
        bus_wbyte({DEV, 1'b1}, a); chk({req, " read addr ack"}, a, 1);
    endtask

    task automatic t_reset;
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 commit", commit_o, 0);
        chk("R1 rd_addr", rd_addr, 0);
    endtask

    task automatic t_single_write;
        logic a;
        int w0 = wr_cnt, c0 = commit_cnt;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a); chk("R2 match ack", a, 1);
        bus_wbyte(8'h12, a);       chk("R3 ptr ack", a, 1);
        chk("R3 ptr loaded", rd_addr, 8'h12);
        bus_wbyte(8'h3C, a);       chk("R4 data ack", a, 1);
        bus_stop;
        model[8'h12] = 8'h3C;
        chk("R4 one strobe", wr_cnt - w0, 1);
        chk("R4 stored", mem[8'h12], 8'h3C);
        chk("R7 commit after data", commit_cnt - c0, 1);
    endtask

    task automatic t_page_wrap;
        logic a;
        logic [7:0] base = 8'h1D;
        int w0 = wr_cnt, c0 = commit_cnt;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a);
        bus_wbyte(base, a);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] ad;
            bus_wbyte(8'(8'h60 + k), a);
            chk("R4 burst ack", a, 1);
            ad = {base[7:3], 3'(base[2:0] + 3'(k))};
            model[ad] = 8'(8'h60 + k);
        end
        bus_stop;
        chk("R5 strobes", wr_cnt - w0, 10);
        chk("R7 one commit", commit_cnt - c0, 1);
        chk("R5 end pointer", rd_addr, 8'h1F);
        for (int i = 8'h17; i <= 8'h20; i++)
            chk("R5 row content", mem[i], model[i]);
    endtask

    task automatic t_dummy_read;
        logic [7:0] d;
        int w0 = wr_cnt, c0 = commit_cnt;
        set_ptr_for_read(8'h1B, "R9");
        bus_rbyte(1'b1, d); chk("R9 byte0", d, model[8'h1B]);
        bus_rbyte(1'b1, d); chk("R10 byte1", d, model[8'h1C]);
        bus_rbyte(1'b0, d); chk("R10 byte2", d, model[8'h1D]);
        bus_stop;
        chk("R10 pointer after", rd_addr, 8'h1E);
        chk("R7 no commit on dummy", commit_cnt - c0, 0);
        chk("R9 no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_current_read;
        logic a;
        logic [7:0] d;
        bus_start;
        bus_wbyte({DEV, 1'b1}, a); chk("R8 addr ack", a, 1);
        bus_rbyte(1'b0, d);        chk("R8 current pointer data", d, model[8'h1E]);
        bus_stop;
    endtask

    task automatic t_nack_release;
        logic a;
        logic [7:0] d;
        int lows = 0;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a);
        bus_wbyte(8'h40, a);
        bus_wbyte(8'h00, a);
        bus_wbyte(8'h00, a);
        bus_stop;
        model[8'h40] = 8'h00; model[8'h41] = 8'h00;
        set_ptr_for_read(8'h40, "R11");
        bus_rbyte(1'b0, d); chk("R11 read byte", d, 8'h00);
        for (int i = 0; i < 9; i++) begin
            wq; scl = 1'b1; wq; if (!sda_line) lows++; wq; scl = 1'b0;
        end
        wq;
        chk("R11 released after NACK", lows, 0);
        bus_stop;
    endtask

    task automatic t_wrap_read;
        logic [7:0] d;
        set_ptr_for_read(8'hFE, "R10");
        bus_rbyte(1'b1, d); chk("R10 at FE", d, model[8'hFE]);
        bus_rbyte(1'b1, d); chk("R10 at FF", d, model[8'hFF]);
        bus_rbyte(1'b0, d); chk("R10 wrap to 00", d, model[8'h00]);
        bus_stop;
        chk("R10 pointer 01", rd_addr, 8'h01);
    endtask

    task automatic t_mismatch;
        logic a;
        int w0 = wr_cnt, c0 = commit_cnt;
        bus_start;
        bus_wbyte({DEV ^ 7'h01, 1'b0}, a); chk("R2 foreign nack", a, 0);
        bus_wbyte(8'h00, a);               chk("R2 ignored byte", a, 0);
        bus_wbyte(8'h00, a);               chk("R2 ignored data", a, 0);
        bus_stop;
        chk("R2 no write", wr_cnt - w0, 0);
        chk("R2 no commit", commit_cnt - c0, 0);
    endtask

    task automatic t_busy;
        logic a;
        int w0 = wr_cnt;
        busy = 1'b1;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a); chk("R6 busy write nack", a, 0);
        bus_wbyte(8'h05, a);       chk("R6 busy no ptr ack", a, 0);
        bus_stop;
        bus_start;
        bus_wbyte({DEV, 1'b1}, a); chk("R6 busy read nack", a, 0);
        bus_stop;
        chk("R6 no write", wr_cnt - w0, 0);
        busy = 1'b0;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a); chk("R6 ack after busy", a, 1);
        bus_stop;
    endtask

    task automatic t_ptr_only;
        logic a;
        int c0 = commit_cnt;
        bus_start;
        bus_wbyte({DEV, 1'b0}, a);
        bus_wbyte(8'h33, a);
        bus_stop;
        chk("R3 ptr only", rd_addr, 8'h33);
        chk("R7 no commit ptr only", commit_cnt - c0, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'((i * 37 + 11) % 256);
        repeat (10) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        repeat (5) @(negedge clk);
        t_single_write;
        t_page_wrap;
        t_dummy_read;
        t_current_read;
        t_nack_release;
        t_wrap_read;
        t_mismatch;
        t_busy;
        t_ptr_only;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule